// File: doc/BRIEF.md
# Program Counter and Branch-Link Unit

This block keeps the current instruction address and a single return-address register for a 32-bit instruction stream in which every instruction is 4 bytes long. On each executed step the address either moves to the next instruction or is redirected. A redirect can be a relative branch, a branch that also records where to come back to, a return through the link register, or a direct load of an arbitrary value such as a return address taken off the stack.

Code that reads the program counter sees the executing address plus 8, as a fetch-ahead pipeline would present it. That same plus-8 value is the base for relative branch targets. The link register always receives the address of the instruction after the call. It holds only the most recent one, so software must spill it before making a nested call.

Top module: `pc_link_unit`

## Requirements
- R1: While rstN is low and after it is released, pcCur is 0, lrOut is 0 and pcRead is 8.
- R2: pcRead always equals pcCur + 8 (modulo 2^32).
- R3: When stepEn is 0, pcCur and lrOut keep their values whatever the command inputs are.
- R4: A step with no command active (loadEn, bxEn, brEn all 0) sets pcCur to pcCur + 4.
- R5: A step with brEn set, as the winning command, sets pcCur to (pcCur + 8) + 4 * brOffset, where brOffset is a 24-bit two's complement instruction count.
- R6: A step with brEn and linkEn set, as the winning command, also writes lrOut with the old pcCur + 4, never the old pcCur.
- R7: linkEn without brEn has no effect on lrOut, and the step proceeds sequentially.
- R8: A step with bxEn, as the winning command, sets pcCur to lrOut and leaves lrOut unchanged.
- R9: A step with loadEn sets pcCur to loadVal in one step and leaves lrOut unchanged.
- R10: When several commands are active in one step, loadEn wins over bxEn, bxEn wins over brEn, and brEn wins over sequential flow. lrOut is written only when the branch path wins with linkEn set.
- R11: A second branch-with-link replaces the first return address in lrOut.
- R12: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | One instruction executes this cycle |
| loadEn | input | 1 | Load pcCur from loadVal |
| loadVal | input | 32 | Value written to pcCur on a load |
| bxEn | input | 1 | Return: pcCur takes lrOut |
| brEn | input | 1 | Relative branch |
| linkEn | input | 1 | With brEn, also record the return address |
| brOffset | input | 24 | Signed branch offset in instructions |
| pcCur | output | 32 | Address of the executing instruction |
| pcRead | output | 32 | Program counter as read by code (pcCur + 8) |
| lrOut | output | 32 | Link register |

## Verification
A wrong internal state shows on pcCur or lrOut at the first clock edge after the step that causes it. It keeps showing there, because every later address is derived from it. A link that records the call address instead of the next one shows on lrOut right away, and again on pcCur after the following return. A priority error shows as a wrong pcCur, or as an lrOut change when a load or return should have won. Wrong sign extension shows only with backward offsets, including the most negative one.

// File: rtl/pc_link_pkg.sv
package pc_link_pkg;
  parameter int ADDR_W = 32;
  parameter int OFF_W  = 24;
  parameter int INSTR_BYTES = 4;
  localparam int INSTR_SHIFT = $clog2(INSTR_BYTES);
  localparam int AHEAD_BYTES = 2 * INSTR_BYTES;

  typedef struct packed {
    logic selLoad;
    logic selBx;
    logic selBr;
    logic wrLink;
    logic advance;
  } pcStrobes_t;
endpackage

// File: rtl/pc_link_ctrl.sv
module pc_link_ctrl
  import pc_link_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic       loadEn,
  input  logic       bxEn,
  input  logic       brEn,
  input  logic       linkEn,
  output pcStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (stepEn) begin
      strobes.advance = 1'b1;
      if (loadEn) begin
        strobes.selLoad = 1'b1;
      end else if (bxEn) begin
        strobes.selBx = 1'b1;
      end else if (brEn) begin
        strobes.selBr  = 1'b1;
        strobes.wrLink = linkEn;
      end
    end
  end

  // R10: a link write only happens with the branch path chosen and no higher command
  assert_link_only_on_branch_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLink |-> (strobes.selBr && !loadEn && !bxEn && brEn));
  // R7: linkEn alone never requests a link write
  assert_link_needs_branch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (linkEn && !brEn) |-> !strobes.wrLink);
endmodule

// File: rtl/pc_link_datapath.sv
module pc_link_datapath
  import pc_link_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobes_t        strobes,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic [OFF_W-1:0]  brOffset,
  output logic [ADDR_W-1:0] pcCur,
  output logic [ADDR_W-1:0] pcRead,
  output logic [ADDR_W-1:0] lrOut
);
  logic [ADDR_W-1:0] pcReg, lrReg, seqAddr, aheadAddr, brDisp, brTarget, pcNext;

  assign seqAddr   = pcReg + ADDR_W'(INSTR_BYTES);
  assign aheadAddr = pcReg + ADDR_W'(AHEAD_BYTES);
  assign brDisp    = {{(ADDR_W-OFF_W){brOffset[OFF_W-1]}}, brOffset} << INSTR_SHIFT;
  assign brTarget  = aheadAddr + brDisp;

  always_comb begin
    pcNext = seqAddr;
    if (strobes.selLoad)    pcNext = loadVal;
    else if (strobes.selBx) pcNext = lrReg;
    else if (strobes.selBr) pcNext = brTarget;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg <= '0;
      lrReg <= '0;
    end else if (strobes.advance) begin
      pcReg <= pcNext;
      if (strobes.wrLink) lrReg <= seqAddr;
    end
  end

  assign pcCur  = pcReg;
  assign pcRead = aheadAddr;
  assign lrOut  = lrReg;

  // R3: no step, no change
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> (pcReg == $past(pcReg) && lrReg == $past(lrReg)));
  // R4: plain step moves one instruction
  assert_seq_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.selLoad && !strobes.selBx && !strobes.selBr)
      |=> pcReg == $past(pcReg) + ADDR_W'(INSTR_BYTES));
  // R6: link holds the address after the call
  assert_link_next_instr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.wrLink) |=> lrReg == $past(pcReg) + ADDR_W'(INSTR_BYTES));
  // R8: return takes the link value and keeps it
  assert_return_from_link_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.selBx) |=> (pcReg == $past(lrReg) && $stable(lrReg)));
  // R9: direct load in one step
  assert_direct_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.selLoad) |=> (pcReg == $past(loadVal) && $stable(lrReg)));
endmodule

// File: rtl/pc_link_unit.sv
module pc_link_unit
  import pc_link_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              bxEn,
  input  logic              brEn,
  input  logic              linkEn,
  input  logic [OFF_W-1:0]  brOffset,
  output logic [ADDR_W-1:0] pcCur,
  output logic [ADDR_W-1:0] pcRead,
  output logic [ADDR_W-1:0] lrOut
);
  pcStrobes_t strobes;

  pc_link_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .loadEn(loadEn),
    .bxEn(bxEn), .brEn(brEn), .linkEn(linkEn), .strobes(strobes)
  );

  pc_link_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadVal(loadVal),
    .brOffset(brOffset), .pcCur(pcCur), .pcRead(pcRead), .lrOut(lrOut)
  );
endmodule

// File: tb/pc_link_unit_tb.sv
module pc_link_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0, loadEn = 1'b0, bxEn = 1'b0, brEn = 1'b0, linkEn = 1'b0;
  logic [31:0] loadVal = '0;
  logic [23:0] brOffset = '0;
  logic [31:0] pcCur, pcRead, lrOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_link_unit u_dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .loadEn(loadEn), .loadVal(loadVal),
    .bxEn(bxEn), .brEn(brEn), .linkEn(linkEn), .brOffset(brOffset),
    .pcCur(pcCur), .pcRead(pcRead), .lrOut(lrOut)
  );

  task automatic checkState(input logic [31:0] expPc, input logic [31:0] expLr, input string req);
    checks++;
    if (pcCur !== expPc) begin
      failures++;
      $display("FAIL %s pcCur actual=%h expected=%h", req, pcCur, expPc);
    end
    checks++;
    if (lrOut !== expLr) begin
      failures++;
      $display("FAIL %s lrOut actual=%h expected=%h", req, lrOut, expLr);
    end
    checks++;
    if (pcRead !== expPc + 32'd8) begin
      failures++;
      $display("FAIL R2 (%s) pcRead actual=%h expected=%h", req, pcRead, expPc + 32'd8);
    end
  endtask

  // drive at a falling edge, let one rising edge act, return at the next falling edge
  task automatic doStep(input bit st, input bit ld, input bit bx, input bit br, input bit lk,
                        input logic [31:0] v, input logic [23:0] off);
    stepEn = st; loadEn = ld; bxEn = bx; brEn = br; linkEn = lk;
    loadVal = v; brOffset = off;
    @(negedge clk);
    stepEn = 0; loadEn = 0; bxEn = 0; brEn = 0; linkEn = 0;
  endtask

  task automatic testReset;
    checkState(32'h0, 32'h0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkState(32'h0, 32'h0, "R1 after reset");
  endtask

  task automatic testSequential;
    for (int i = 0; i < 3; i++) doStep(1, 0, 0, 0, 0, 0, 0);
    checkState(32'd12, 32'h0, "R4 sequential");
  endtask

  task automatic testBranch;
    doStep(1, 0, 0, 1, 0, 0, 24'd4);
    checkState(32'd36, 32'h0, "R5 forward branch");
    doStep(1, 0, 0, 1, 0, 0, 24'hFFFFFD);
    checkState(32'd32, 32'h0, "R5 backward branch");
  endtask

  task automatic testBranchLink;
    doStep(1, 0, 0, 1, 1, 0, 24'd10);
    checkState(32'd80, 32'd36, "R6 branch with link");
    doStep(1, 0, 0, 0, 1, 0, 24'd10);
    checkState(32'd84, 32'd36, "R7 link without branch");
  endtask

  task automatic testStall;
    doStep(0, 1, 1, 1, 1, 32'hDEAD0000, 24'd7);
    checkState(32'd84, 32'd36, "R3 stall ignores commands");
  endtask

  task automatic testReturnLoad;
    doStep(1, 0, 1, 0, 0, 0, 0);
    checkState(32'd36, 32'd36, "R8 return from link");
    doStep(1, 1, 0, 0, 0, 32'h1000, 0);
    checkState(32'h1000, 32'd36, "R9 direct load");
  endtask

  task automatic testNested;
    doStep(1, 0, 0, 1, 1, 0, 24'd0);
    checkState(32'h1008, 32'h1004, "R11 first call");
    doStep(1, 0, 0, 1, 1, 0, 24'd0);
    checkState(32'h1010, 32'h100C, "R11 nested call overwrites");
  endtask

  task automatic testPriority;
    doStep(1, 1, 1, 1, 1, 32'h200, 24'd5);
    checkState(32'h200, 32'h100C, "R10 load beats all");
    doStep(1, 0, 1, 1, 1, 0, 24'd5);
    checkState(32'h100C, 32'h100C, "R10 return beats branch-link");
  endtask

  task automatic testWrap;
    doStep(1, 1, 0, 0, 0, 32'hFFFFFFF8, 0);
    doStep(1, 0, 0, 0, 0, 0, 0);
    checkState(32'hFFFFFFFC, 32'h100C, "R12 near top");
    doStep(1, 0, 0, 0, 0, 0, 0);
    checkState(32'h0, 32'h100C, "R12 sequential wrap");
    doStep(1, 0, 0, 1, 0, 0, 24'h800000);
    checkState(32'hFE000008, 32'h100C, "R5 most negative offset");
    doStep(1, 1, 0, 0, 0, 32'h10, 0);
    doStep(1, 0, 0, 1, 0, 0, 24'hFFFFF8);
    checkState(32'hFFFFFFF8, 32'h100C, "R12 branch wrap below zero");
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testSequential();
    testBranch();
    testBranchLink();
    testStall();
    testReturnLoad();
    testNested();
    testPriority();
    testWrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule